// File: doc/BRIEF.md
# Bus-Matching FIFO Width Converter

This block is a single-clock FIFO whose write and read ports may each be 9 or 18 bits wide, chosen independently. Storage is a byte array addressed in 9-bit units. An 18-bit write lays two bytes into the array, and an 18-bit read takes two bytes out. A 9-bit port moves one byte per transfer. Mixed widths therefore split or pack words with no separate assembly register.

The two width selects and a byte-order select are captured by a synchronous master-reset pulse and hold until the next one. The byte-order select decides which half of an 18-bit word corresponds to the earlier byte of the 9-bit stream. A partial-reset pulse empties the FIFO and keeps the captured settings. Occupancy is counted in bytes. The empty and full flags compare that count with the size of one transfer on the port concerned, so an 18-bit read waits until two bytes are present. The read port shows ahead: whenever `empty` is low, `rd_data` holds the oldest entry, and `rd_en` consumes it.

Top module: `bmf_top`

## Requirements
- R1: After asynchronous reset, and one cycle after a master-reset pulse, `empty` is 1 and `full` is 0.
- R2: `cfg_wr_narrow`, `cfg_rd_narrow` and `cfg_little` take effect only in a cycle where `mrst` is high. Changing them at any other time has no effect on the transfers that follow.
- R3: With `cfg_rd_narrow`=0 the read port delivers 18-bit words. With `cfg_rd_narrow`=1 it delivers one byte in `rd_data[8:0]`, and `rd_data[17:9]` is 0.
- R4: 18-bit write with 9-bit read, big-endian (`cfg_little`=0): each word yields two reads, `wr_data[17:9]` first and then `wr_data[8:0]`.
- R5: 18-bit write with 9-bit read, little-endian (`cfg_little`=1): `wr_data[8:0]` is read first and then `wr_data[17:9]`.
- R6: 9-bit write with 18-bit read: `empty` stays 1 while fewer than two bytes are stored. The first byte written lands in `rd_data[17:9]` when big-endian and in `rd_data[8:0]` when little-endian.
- R7: With both ports 9 bits, the FIFO holds DEPTH bytes before `full` rises. With an 18-bit write port it holds DEPTH/2 words.
- R8: A write while `full` is 1 and a read while `empty` is 1 are ignored and leave the stored data unchanged.
- R9: A `prst` pulse makes `empty` 1 one cycle later and discards all stored bytes. It keeps the captured widths and byte order.
- R10: With matching port widths (9→9 or 18→18, in either byte order), data leaves in write order and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrst | input | 1 | Synchronous master reset: clears contents and captures configuration |
| prst | input | 1 | Synchronous partial reset: clears contents only |
| cfg_wr_narrow | input | 1 | 1 = 9-bit write port, 0 = 18-bit (sampled with mrst) |
| cfg_rd_narrow | input | 1 | 1 = 9-bit read port, 0 = 18-bit (sampled with mrst) |
| cfg_little | input | 1 | 1 = little-endian, 0 = big-endian (sampled with mrst) |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data; a 9-bit port uses bits 8:0 |
| full | output | 1 | No room for one write transfer |
| rd_en | input | 1 | Read request (consumes the shown entry) |
| rd_data | output | 18 | Oldest entry, valid while empty is 0 |
| empty | output | 1 | Less than one read transfer stored |

## Verification
The assertions rely on three assumptions about the inputs. `mrst` and `prst` are treated as synchronous pulses sampled at the clock edge. DEPTH is a power of two, so the byte pointers wrap by plain overflow. Configuration inputs may change freely outside a master reset. The bench drives every input a fixed delay after the rising edge. It issues master and partial resets with the request lines low. It deliberately toggles the configuration pins between master resets and issues requests against a full or empty FIFO, so the hold and ignore properties are exercised at their edges.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  typedef struct packed {
    logic wr_narrow;
    logic rd_narrow;
    logic little;
  } bmf_cfg_t;
endpackage

// File: rtl/bmf_cfg_latch.sv
module bmf_cfg_latch
  import bmf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  bmf_cfg_t cfg_d,
  output bmf_cfg_t cfg_q
);
  bmf_cfg_t cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    if (load) cfg_n = cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/bmf_occupancy.sv
module bmf_occupancy #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          wr_two,
  input  logic          rd_two,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] count, count_n, wsz, rsz, free;
  logic [AW-1:0] wptr_n, rptr_n;

  assign wsz     = wr_two ? CW'(2) : CW'(1);
  assign rsz     = rd_two ? CW'(2) : CW'(1);
  assign free    = CW'(DEPTH) - count;
  assign full    = free < wsz;
  assign empty   = count < rsz;
  assign wr_fire = wr_req && !full && !clr;
  assign rd_fire = rd_req && !empty && !clr;

  always_comb begin
    wptr_n  = wptr;
    rptr_n  = rptr;
    count_n = count;
    if (clr) begin
      wptr_n  = '0;
      rptr_n  = '0;
      count_n = '0;
    end else begin
      if (wr_fire) wptr_n = wptr + wsz[AW-1:0];
      if (rd_fire) rptr_n = rptr + rsz[AW-1:0];
      count_n = count + (wr_fire ? wsz : '0) - (rd_fire ? rsz : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req && !clr) |=> $stable(count));
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req && !clr) |=> $stable(count));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/bmf_byte_ram.sv
module bmf_byte_ram #(
  parameter int BYTE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              we_two,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wb0,
  input  logic [BYTE_W-1:0] wb1,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rb0,
  output logic [BYTE_W-1:0] rb1
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     waddr_p1;
  logic [BYTE_W-1:0] rlane [2];

  assign waddr_p1 = waddr + AW'(1);

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wb0;
      if (we_two) mem[waddr_p1] <= wb1;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_rlane
    logic [AW-1:0] a;
    assign a        = raddr + AW'(k);
    assign rlane[k] = mem[a];
  end

  assign rb0 = rlane[0];
  assign rb1 = rlane[1];
endmodule

// File: rtl/bmf_top.sv
module bmf_top
  import bmf_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int DEPTH  = 16,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_wr_narrow,
  input  logic              cfg_rd_narrow,
  input  logic              cfg_little,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty
);
  bmf_cfg_t          cfg_d, cfg_q;
  logic              clr, wr_fire, rd_fire;
  logic [AW-1:0]     wptr, rptr;
  logic [BYTE_W-1:0] wb0, wb1, rb0, rb1;
  logic [BYTE_W-1:0] w_hi, w_lo;

  assign cfg_d = '{wr_narrow: cfg_wr_narrow, rd_narrow: cfg_rd_narrow, little: cfg_little};
  assign clr   = mrst || prst;

  bmf_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .load(mrst), .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  bmf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_req(wr_en), .rd_req(rd_en),
    .wr_two(!cfg_q.wr_narrow), .rd_two(!cfg_q.rd_narrow),
    .wptr(wptr), .rptr(rptr), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .full(full), .empty(empty)
  );

  assign w_hi = wr_data[WORD_W-1:BYTE_W];
  assign w_lo = wr_data[BYTE_W-1:0];

  // Write split: wb0 is the earlier byte of the byte stream.
  always_comb begin
    wb0 = w_lo;
    wb1 = w_hi;
    if (!cfg_q.wr_narrow && !cfg_q.little) begin
      wb0 = w_hi;
      wb1 = w_lo;
    end
  end

  bmf_byte_ram #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_fire), .we_two(!cfg_q.wr_narrow),
    .waddr(wptr), .wb0(wb0), .wb1(wb1),
    .raddr(rptr), .rb0(rb0), .rb1(rb1)
  );

  // Read pack: rb0 is the earlier byte.
  always_comb begin
    if (cfg_q.rd_narrow)  rd_data = {{BYTE_W{1'b0}}, rb0};
    else if (cfg_q.little) rd_data = {rb1, rb0};
    else                   rd_data = {rb0, rb1};
  end

  // R1
  mrst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (empty && !full));
  // R9
  prst_keep_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prst && !mrst) |=> (empty && $stable(cfg_q)));
  // R3
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.rd_narrow && !empty) |-> (rd_data[WORD_W-1:BYTE_W] == '0));
endmodule

// File: tb/bmf_top_tb.sv
module bmf_top_tb;
  logic        clk = 1'b0;
  logic        rst_n, mrst, prst, cwn, crn, cl, wr_en, rd_en;
  logic [17:0] wr_data;
  logic [17:0] rd_data;
  logic        full, empty;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  bmf_top u_dut (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .prst(prst),
    .cfg_wr_narrow(cwn), .cfg_rd_narrow(crn), .cfg_little(cl),
    .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_mrst(logic wn, logic rn, logic le);
    cwn = wn; crn = rn; cl = le; mrst = 1'b1;
    step();
    mrst = 1'b0;
  endtask

  task automatic push(logic [17:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pop(string req, logic [17:0] exp);
    chk({req, " not empty"}, {31'b0, empty}, 32'd0);
    chk(req, {14'b0, rd_data}, {14'b0, exp});
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 empty after rst_n", {31'b0, empty}, 32'd1);
    chk("R1 full after rst_n", {31'b0, full}, 32'd0);
    push(18'h00011);
    do_mrst(1'b1, 1'b1, 1'b0);
    chk("R1 empty after mrst", {31'b0, empty}, 32'd1);
    chk("R1 full after mrst", {31'b0, full}, 32'd0);
  endtask

  task automatic t_narrow_both();
    do_mrst(1'b1, 1'b1, 1'b0);
    rd_en = 1'b1; step(); rd_en = 1'b0;            // R8 read on empty
    chk("R8 empty read ignored", {31'b0, empty}, 32'd1);
    for (int i = 0; i < 16; i++) push(18'(9'h100 + i));
    chk("R7 full at 16 bytes", {31'b0, full}, 32'd1);
    push(18'h000FF);                               // R8 write on full
    for (int i = 0; i < 16; i++) pop("R10 9to9 order", 18'(9'h100 + i));
    chk("R8 no extra byte", {31'b0, empty}, 32'd1);
  endtask

  task automatic t_split(logic le);
    do_mrst(1'b0, 1'b1, le);
    for (int i = 0; i < 8; i++) push({9'(9'h040 + i), 9'(9'h180 + i)});
    chk("R7 full at 8 words", {31'b0, full}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      if (!le) begin
        pop("R4 big upper first", 18'(9'h040 + i));
        pop("R4 big lower second", 18'(9'h180 + i));
      end else begin
        pop("R5 little lower first", 18'(9'h180 + i));
        pop("R5 little upper second", 18'(9'h040 + i));
      end
    end
    chk("R3 narrow drained", {31'b0, empty}, 32'd1);
  endtask

  task automatic t_pack(logic le);
    do_mrst(1'b1, 1'b0, le);
    push(18'h0012A);
    chk("R6 one byte still empty", {31'b0, empty}, 32'd1);
    push(18'h001B5);
    chk("R6 two bytes readable", {31'b0, empty}, 32'd0);
    if (!le) pop("R6 big pack", {9'h12A, 9'h1B5});
    else     pop("R6 little pack", {9'h1B5, 9'h12A});
    for (int i = 0; i < 16; i++) push(18'(i));
    chk("R7 9in full at 16 bytes", {31'b0, full}, 32'd1);
  endtask

  task automatic t_wide(logic le);
    do_mrst(1'b0, 1'b0, le);
    push(18'h2A5C3);
    push(18'h1F00E);
    pop("R10 18to18 first", 18'h2A5C3);
    pop("R3 18to18 second", 18'h1F00E);
    chk("R10 wide drained", {31'b0, empty}, 32'd1);
  endtask

  task automatic t_cfg_hold();
    do_mrst(1'b0, 1'b1, 1'b0);
    cwn = 1'b1; crn = 1'b0; cl = 1'b1;
    step();
    push(18'h3C0A5);
    pop("R2 hold width big first", 18'h001E0);
    pop("R2 hold second byte", 18'h000A5);
  endtask

  task automatic t_partial();
    do_mrst(1'b0, 1'b1, 1'b1);
    push(18'h11111);
    push(18'h22222);
    prst = 1'b1; step(); prst = 1'b0;
    chk("R9 empty after prst", {31'b0, empty}, 32'd1);
    push({9'h0AB, 9'h1CD});
    pop("R9 little kept", 18'h001CD);
    pop("R9 data discarded", 18'h000AB);
    chk("R9 drained", {31'b0, empty}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mrst = 1'b0; prst = 1'b0; cwn = 1'b0; crn = 1'b0; cl = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_narrow_both();
    t_split(1'b0);
    t_split(1'b1);
    t_pack(1'b0);
    t_pack(1'b1);
    t_wide(1'b0);
    t_wide(1'b1);
    t_cfg_hold();
    t_partial();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule